// File: doc/BRIEF.md
# Per-Slave Request Arbiter with Outstanding Read/Write Ceilings

This block sits in front of one slave port of an interconnect and chooses, each cycle, at most one of up to sixteen masters whose request may go to that slave. Every master presents a request bit and a direction bit (read or write). The arbiter issues a registered one-hot grant together with a flag that says whether the granted transfer is a write.

Two selection algorithms are available and are chosen at run time by a mode input. In fixed-priority mode the order comes from a programmable list of master numbers, so each slave can rank the masters differently. In round-robin mode the search begins just past the master that was last granted. No grant of any kind is issued while the slave reports that it is busy. A master that is not granted simply keeps its request up.

The arbiter also tracks how many reads and how many writes granted to the slave have not yet completed. Each kind is capped by its own limit. When a count sits at its limit, requests of that kind are passed over and requests of the other kind may still win. Completion pulses lower the counts. A completion that arrives while its count is already zero is dropped and reported on an error output.

Top module: `slv_port_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `gnt` is all zero, `gnt_is_wr`, `cpl_err`, `rd_outstanding` and `wr_outstanding` are zero, and the round-robin pointer holds master N-1.
- R2: `gnt` has at most one bit set. It is registered: requests sampled at one rising edge produce the grant that is visible after that edge. Only a master whose request was high can be granted. `gnt_is_wr` equals the `req_wr` bit of the granted master.
- R3: While `slave_busy` is high no grant is issued and the outstanding counts do not change. A request held through the busy period is granted on the first edge at which `slave_busy` is low.
- R4: When `mode` is 1, or any value other than 2, fixed priority applies. List entry k is the zero-based master number in `prio_list[4k+3:4k]` (for N=16). Entry 0 has the highest precedence. The eligible master that appears earliest in the list wins.
- R5: When `mode` is 2, the search starts at the master one above the last granted master and wraps from N-1 to 0. The pointer is updated on every grant in either mode.
- R6: `rd_outstanding` rises by one on each read grant and falls by one on each `rd_done` pulse. When both happen in the same cycle it is unchanged.
- R7: When `rd_outstanding` equals RD_LIMIT (default 2), no read is granted. A completion in the same cycle frees the slot only from the following cycle.
- R8: `wr_outstanding` follows the same counting rules as reads and has its own WR_LIMIT (default 2). Writes can still be granted while reads are at their limit, and reads can still be granted while writes are at theirs.
- R9: A `rd_done` or `wr_done` pulse while the matching count is zero leaves that count at zero. It raises `cpl_err` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 2 = round robin, anything else = fixed priority |
| prio_list | input | N*IW | Fixed-priority list; entry k in bits [k*IW +: IW], entry 0 highest |
| req | input | N | Request bit per master |
| req_wr | input | N | Direction per master: 1 = write, 0 = read |
| slave_busy | input | 1 | Slave cannot accept a transfer this cycle |
| rd_done | input | 1 | One read to this slave has completed |
| wr_done | input | 1 | One write to this slave has completed |
| gnt | output | N | Registered one-hot grant |
| gnt_is_wr | output | 1 | Granted transfer is a write |
| rd_outstanding | output | CNT_W | Reads granted and not yet completed |
| wr_outstanding | output | CNT_W | Writes granted and not yet completed |
| cpl_err | output | 1 | Completion arrived with its count at zero (previous cycle) |

## Verification
The grant, its direction flag and both outstanding counts all update at the same rising edge that samples the requests, the busy flag and the completions. They are therefore due one cycle after the stimulus. `cpl_err` is also due one cycle after the stray completion, and it is low again on the cycle after that. The bench drives every input shortly after a rising edge and reads every output shortly after the next rising edge. Each check thus compares the result of exactly one arbitration step. Multi-step scenarios, such as hitting a limit and then freeing it, are walked one edge at a time, and the expected value is written for every step.

// File: rtl/slv_arb_pkg.sv
package slv_arb_pkg;

    localparam logic [1:0] MODE_FIXED = 2'd1;
    localparam logic [1:0] MODE_RR    = 2'd2;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/slv_arb_fixed_pick.sv
module slv_arb_fixed_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]    elig,
    input  logic [N*IW-1:0] prio_list,
    output logic            valid,
    output logic [IW-1:0]   idx
);

    logic [IW-1:0] entry;

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        entry = '0;
        for (int k = 0; k < N; k++) begin
            entry = prio_list[k*IW +: IW];
            if (!valid && int'(entry) < N && elig[entry]) begin
                valid = 1'b1;
                idx   = entry;
            end
        end
    end

endmodule

// File: rtl/slv_arb_rr_pick.sv
module slv_arb_rr_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  elig,
    input  logic [IW-1:0] last,
    output logic          valid,
    output logic [IW-1:0] idx
);

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int off = 1; off <= N; off++) begin
            if (!valid && elig[(int'(last) + off) % N]) begin
                valid = 1'b1;
                idx   = IW'((int'(last) + off) % N);
            end
        end
    end

endmodule

// File: rtl/slv_arb_counter.sv
module slv_arb_counter #(
    parameter int LIMIT = 2,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         full,
    output logic         dec_empty
);

    logic [W-1:0] count_d, count_q;
    logic         do_inc, do_dec;

    always_comb begin
        dec_empty = dec && (count_q == '0);
        do_dec    = dec && (count_q != '0);
        do_inc    = inc && (count_q != {W{1'b1}});
        count_d   = count_q;
        if (do_inc && !do_dec) begin
            count_d = count_q + 1'b1;
        end else if (do_dec && !do_inc) begin
            count_d = count_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;
    assign full  = (count_q >= W'(LIMIT));

endmodule

// File: rtl/slv_port_arbiter.sv
module slv_port_arbiter
    import slv_arb_pkg::*;
#(
    parameter  int N        = 16,
    parameter  int RD_LIMIT = 2,
    parameter  int WR_LIMIT = 2,
    localparam int IW       = $clog2(N),
    localparam int CNT_W    = $clog2(max2(RD_LIMIT, WR_LIMIT) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [N*IW-1:0]   prio_list,
    input  logic [N-1:0]      req,
    input  logic [N-1:0]      req_wr,
    input  logic              slave_busy,
    input  logic              rd_done,
    input  logic              wr_done,
    output logic [N-1:0]      gnt,
    output logic              gnt_is_wr,
    output logic [CNT_W-1:0]  rd_outstanding,
    output logic [CNT_W-1:0]  wr_outstanding,
    output logic              cpl_err
);

    typedef struct packed {
        logic [N-1:0]  gnt;
        logic          gnt_wr;
        logic [IW-1:0] last;
        logic          err;
    } arb_state_t;

    arb_state_t    st_d, st_q;

    logic [N-1:0]  elig;
    logic          rd_full, wr_full;
    logic          rd_bad, wr_bad;
    logic          fix_valid, rr_valid, sel_valid;
    logic [IW-1:0] fix_idx, rr_idx, sel_idx;
    logic          rd_inc, wr_inc;

    // Eligibility per master: request up, slave free, ceiling of its kind not reached
    for (genvar i = 0; i < N; i++) begin : g_elig
        assign elig[i] = req[i] && !slave_busy && (req_wr[i] ? !wr_full : !rd_full);
    end

    slv_arb_fixed_pick #(.N(N), .IW(IW)) u_fixed (
        .elig      (elig),
        .prio_list (prio_list),
        .valid     (fix_valid),
        .idx       (fix_idx)
    );

    slv_arb_rr_pick #(.N(N), .IW(IW)) u_rr (
        .elig  (elig),
        .last  (st_q.last),
        .valid (rr_valid),
        .idx   (rr_idx)
    );

    always_comb begin
        if (mode == MODE_RR) begin
            sel_valid = rr_valid;
            sel_idx   = rr_idx;
        end else begin
            sel_valid = fix_valid;
            sel_idx   = fix_idx;
        end
        rd_inc = sel_valid && !req_wr[sel_idx];
        wr_inc = sel_valid &&  req_wr[sel_idx];

        st_d        = st_q;
        st_d.gnt    = '0;
        st_d.gnt_wr = 1'b0;
        st_d.err    = rd_bad || wr_bad;
        if (sel_valid) begin
            st_d.gnt[sel_idx] = 1'b1;
            st_d.gnt_wr       = req_wr[sel_idx];
            st_d.last         = sel_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.gnt    <= '0;
            st_q.gnt_wr <= 1'b0;
            st_q.last   <= IW'(N - 1);
            st_q.err    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    slv_arb_counter #(.LIMIT(RD_LIMIT), .W(CNT_W)) u_rd_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (rd_inc),
        .dec       (rd_done),
        .count     (rd_outstanding),
        .full      (rd_full),
        .dec_empty (rd_bad)
    );

    slv_arb_counter #(.LIMIT(WR_LIMIT), .W(CNT_W)) u_wr_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (wr_inc),
        .dec       (wr_done),
        .count     (wr_outstanding),
        .full      (wr_full),
        .dec_empty (wr_bad)
    );

    assign gnt       = st_q.gnt;
    assign gnt_is_wr = st_q.gnt_wr;
    assign cpl_err   = st_q.err;

endmodule

// File: rtl/slv_arb_checker.sv
module slv_arb_checker #(
    parameter int N        = 16,
    parameter int RD_LIMIT = 2,
    parameter int WR_LIMIT = 2,
    parameter int CNT_W    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     req,
    input logic             slave_busy,
    input logic             rd_done,
    input logic             wr_done,
    input logic [N-1:0]     gnt,
    input logic             gnt_is_wr,
    input logic [CNT_W-1:0] rd_outstanding,
    input logic [CNT_W-1:0] wr_outstanding,
    input logic             cpl_err
);

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    a_r2_gnt_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |-> ((gnt & ~$past(req)) == '0));

    a_r3_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        slave_busy |=> (gnt == '0));

    a_r7_rd_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_outstanding == CNT_W'(RD_LIMIT)) |=> !((|gnt) && !gnt_is_wr));

    a_r8_wr_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_outstanding == CNT_W'(WR_LIMIT)) |=> !((|gnt) && gnt_is_wr));

    a_r9_stray_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_done && rd_outstanding == '0) || (wr_done && wr_outstanding == '0)) |=> cpl_err);

    a_r9_stray_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && rd_outstanding == '0 && (gnt == '0)) |=> (rd_outstanding <= CNT_W'(1)));

endmodule

bind slv_port_arbiter slv_arb_checker #(
    .N(N), .RD_LIMIT(RD_LIMIT), .WR_LIMIT(WR_LIMIT), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .slave_busy(slave_busy),
    .rd_done(rd_done), .wr_done(wr_done), .gnt(gnt), .gnt_is_wr(gnt_is_wr),
    .rd_outstanding(rd_outstanding), .wr_outstanding(wr_outstanding),
    .cpl_err(cpl_err)
);

// File: tb/slv_port_arbiter_test.sv
module slv_port_arbiter_test;

    localparam int N  = 16;
    localparam int IW = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'd1;
    logic [N*IW-1:0] prio_list = '0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  req_wr = '0;
    logic          slave_busy = 1'b0;
    logic          rd_done = 1'b0;
    logic          wr_done = 1'b0;
    logic [N-1:0]  gnt;
    logic          gnt_is_wr;
    logic [CW-1:0] rd_outstanding;
    logic [CW-1:0] wr_outstanding;
    logic          cpl_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    slv_port_arbiter #(.N(N), .RD_LIMIT(2), .WR_LIMIT(2)) uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .prio_list(prio_list),
        .req(req), .req_wr(req_wr), .slave_busy(slave_busy),
        .rd_done(rd_done), .wr_done(wr_done), .gnt(gnt), .gnt_is_wr(gnt_is_wr),
        .rd_outstanding(rd_outstanding), .wr_outstanding(wr_outstanding),
        .cpl_err(cpl_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_identity_list();
        for (int k = 0; k < N; k++) prio_list[k*IW +: IW] = IW'(k);
    endtask

    // Order 5,7,3,4 then the remaining masters ascending
    task automatic set_custom_list();
        int pos;
        prio_list[0*IW +: IW] = 4'd5;
        prio_list[1*IW +: IW] = 4'd7;
        prio_list[2*IW +: IW] = 4'd3;
        prio_list[3*IW +: IW] = 4'd4;
        pos = 4;
        for (int m = 0; m < N; m++) begin
            if (m != 5 && m != 7 && m != 3 && m != 4) begin
                prio_list[pos*IW +: IW] = IW'(m);
                pos++;
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; req_wr = '0; slave_busy = 1'b0;
        rd_done = 1'b0; wr_done = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic test_reset();
        do_reset();
        check("R1 gnt", gnt, 0);
        check("R1 gnt_is_wr", gnt_is_wr, 0);
        check("R1 rd_outstanding", rd_outstanding, 0);
        check("R1 wr_outstanding", wr_outstanding, 0);
        check("R1 cpl_err", cpl_err, 0);
        tick();
        check("R1 gnt idle after release", gnt, 0);
    endtask

    task automatic test_fixed_identity();
        mode = 2'd1; set_identity_list();
        req = (1 << 3) | (1 << 7); req_wr = '0;
        tick();
        check("R4 identity list picks 3", gnt, 32'h8);
        check("R2 read flag", gnt_is_wr, 0);
        check("R6 read count up", rd_outstanding, 1);
        req = '0; rd_done = 1'b1;
        tick();
        check("R2 no req no grant", gnt, 0);
        check("R6 read count down", rd_outstanding, 0);
        rd_done = 1'b0;
    endtask

    task automatic test_custom_limits();
        mode = 2'd1; set_custom_list();
        req = (1 << 3) | (1 << 4) | (1 << 7); req_wr = '0;
        tick();
        check("R4 custom list picks 7", gnt, 32'h80);
        req = (1 << 3) | (1 << 4);
        tick();
        check("R4 custom list picks 3", gnt, 32'h8);
        check("R6 two reads", rd_outstanding, 2);
        req = (1 << 4);
        tick();
        check("R7 read blocked at limit", gnt, 0);
        check("R7 count held", rd_outstanding, 2);
        req_wr = (1 << 4);
        tick();
        check("R8 write passes read limit", gnt, 32'h10);
        check("R8 write flag", gnt_is_wr, 1);
        check("R8 write count", wr_outstanding, 1);
        req_wr = '0; rd_done = 1'b1;
        tick();
        check("R7 same-cycle completion still blocks", gnt, 0);
        check("R6 read count after done", rd_outstanding, 1);
        rd_done = 1'b0;
        tick();
        check("R7 freed slot granted", gnt, 32'h10);
        check("R7 back at limit", rd_outstanding, 2);
        req = '0; rd_done = 1'b1;
        tick(); tick();
        rd_done = 1'b0; wr_done = 1'b1;
        tick();
        wr_done = 1'b0;
        check("R6 drained reads", rd_outstanding, 0);
        check("R8 drained writes", wr_outstanding, 0);
    endtask

    task automatic test_write_limit_mode3();
        mode = 2'd3; set_custom_list();
        req = (1 << 1) | (1 << 2) | (1 << 6); req_wr = req;
        tick();
        check("R4 mode 3 fixed picks 1", gnt, 32'h2);
        req = (1 << 2) | (1 << 6); req_wr = req;
        tick();
        check("R4 mode 3 fixed picks 2", gnt, 32'h4);
        check("R8 two writes", wr_outstanding, 2);
        req = (1 << 6); req_wr = req;
        tick();
        check("R8 write blocked at limit", gnt, 0);
        req = (1 << 3) | (1 << 5); req_wr = '0;
        tick();
        check("R8 read passes write limit, 5 first", gnt, 32'h20);
        mode = 2'd0; req = (1 << 3) | (1 << 7);
        tick();
        check("R4 mode 0 fixed picks 7", gnt, 32'h80);
        req = '0; rd_done = 1'b1; wr_done = 1'b1;
        tick(); tick();
        rd_done = 1'b0; wr_done = 1'b0;
        check("R6 drained", rd_outstanding, 0);
        check("R8 drained", wr_outstanding, 0);
    endtask

    task automatic test_busy();
        mode = 2'd1; set_identity_list();
        req = (1 << 9); req_wr = '0; slave_busy = 1'b1;
        tick();
        check("R3 busy blocks grant", gnt, 0);
        check("R3 busy keeps count", rd_outstanding, 0);
        tick();
        check("R3 still blocked", gnt, 0);
        slave_busy = 1'b0;
        tick();
        check("R3 granted after busy", gnt, 32'h200);
        req = '0; rd_done = 1'b1;
        tick();
        rd_done = 1'b0;
    endtask

    task automatic test_simultaneous();
        req = (1 << 2); req_wr = '0;
        tick();
        check("R6 one read", rd_outstanding, 1);
        rd_done = 1'b1;
        tick();
        check("R6 grant and done same cycle", gnt, 32'h4);
        check("R6 count unchanged", rd_outstanding, 1);
        req = '0;
        tick();
        rd_done = 1'b0;
        check("R6 back to zero", rd_outstanding, 0);
    endtask

    task automatic test_stray();
        rd_done = 1'b1;
        tick();
        rd_done = 1'b0;
        check("R9 read stray flagged", cpl_err, 1);
        check("R9 read count stays zero", rd_outstanding, 0);
        tick();
        check("R9 flag one cycle", cpl_err, 0);
        wr_done = 1'b1;
        tick();
        wr_done = 1'b0;
        check("R9 write stray flagged", cpl_err, 1);
        check("R9 write count stays zero", wr_outstanding, 0);
        tick();
        check("R9 write flag clears", cpl_err, 0);
    endtask

    task automatic rr_step(input logic [N-1:0] r, input int exp_idx, input string tag);
        req = r; req_wr = '0;
        tick();
        check(tag, gnt, 32'(1) << exp_idx);
        req = '0; rd_done = 1'b1;
        tick();
        rd_done = 1'b0;
    endtask

    task automatic test_round_robin();
        do_reset();
        mode = 2'd2;
        rr_step((1 << 2) | (1 << 9) | (1 << 14), 2,  "R5 from reset pointer");
        rr_step((1 << 2) | (1 << 9) | (1 << 14), 9,  "R5 next after 2");
        rr_step((1 << 2) | (1 << 9) | (1 << 14), 14, "R5 next after 9");
        rr_step((1 << 2) | (1 << 9) | (1 << 14), 2,  "R5 wrap to 2");
        rr_step((1 << 0) | (1 << 15), 15, "R5 picks 15 after 2");
        rr_step((1 << 0) | (1 << 15), 0,  "R5 wrap 15 to 0");
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1;
        test_reset();
        test_fixed_identity();
        test_custom_limits();
        test_write_limit_mode3();
        test_busy();
        test_simultaneous();
        test_stray();
        test_round_robin();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule